// File: doc/BRIEF.md
# Serial Memory Write-Protect Controller

This block sits between the command decoder of a serial memory and its 256-byte array. For every pending write it decides whether the data may reach the array. Two protection sources combine. A one-time software lock guards the lower half of the array. An external protect pin guards the whole array. The lock behaves like a fuse. Once a lock command sets it, a normal command cannot clear it. Only a special clear command can release it, and only while a high-voltage qualifier is present.

A write is always timed in full, whether or not protection blocks it. When the decoder starts a write cycle, the block holds a busy flag for a fixed number of clocks. It then issues a commit pulse only if the write was allowed when the cycle began. Blocked writes are still acknowledged by the decoder, and their data is dropped. The lock register powers up cleared. A test load port presets it and stands in for the nonvolatile bit.

Top module: `wp_ctrl`

## Requirements
- R1: After reset the lock is clear, `wr_busy` and `wr_commit` are 0, `cmd_done` is 0, and `lock_code_ack` is 1.
- R2: With the pin low and the lock set, `wr_allow` is 0 for addresses 0x00 to 0x7F and 1 for addresses 0x80 to 0xFF. With the pin low and the lock clear, `wr_allow` is 1 for every address.
- R3: With `prot_pin` high, `wr_allow` is 0 for every address, whether or not the lock is set.
- R4: A `lock_set_req` while `prot_pin` is high is refused. The following cycle shows `cmd_done`=1 and `cmd_ok`=0, and the lock stays clear.
- R5: A `lock_set_req` while the pin is low and the lock is clear is accepted. The following cycle shows `cmd_done`=1 and `cmd_ok`=1, and from that cycle on the lock is set and `lock_code_ack` is 0.
- R6: Once the lock is set, `lock_code_ack` stays 0. Further set requests report `cmd_ok`=0. A clear request with `hv_ok`=0 reports `cmd_ok`=0 and leaves the lock set.
- R7: A `lock_clr_req` with `hv_ok`=1 clears the lock and reports `cmd_ok`=1 in the following cycle. If a clear and a set arrive in the same cycle, the clear takes priority.
- R8: A `wr_start` pulse while idle raises `wr_busy` for exactly `WC_CYCLES` clock cycles, beginning in the next cycle. `wr_commit` pulses once, in the first cycle `wr_busy` is low again, and only if `wr_allow` was 1 for `wr_addr` in the start cycle. The busy length is the same whether the write is allowed or blocked.
- R9: A `wr_start` that arrives while `wr_busy` is 1 is ignored. It neither extends the busy time nor changes the commit decision.
- R10: With `tl_en`=1, the lock takes the value of `tl_val` at the next clock edge. This overrides any lock command in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prot_pin | input | 1 | Hardware protect level (1 = protect all) |
| lock_set_req | input | 1 | One-cycle pulse: lock-set command completed |
| lock_clr_req | input | 1 | One-cycle pulse: lock-clear command completed |
| hv_ok | input | 1 | High-voltage-present qualifier, sampled with `lock_clr_req` |
| tl_en | input | 1 | Test load enable for the lock bit |
| tl_val | input | 1 | Test load value for the lock bit |
| wr_addr | input | ADDR_W | Target byte address of the pending write |
| wr_start | input | 1 | One-cycle pulse: start an internal write cycle |
| wr_allow | output | 1 | Write to `wr_addr` permitted now |
| lock_code_ack | output | 1 | Lock-command control code would be acknowledged |
| cmd_done | output | 1 | Lock command outcome valid this cycle |
| cmd_ok | output | 1 | Lock command accepted (valid with `cmd_done`) |
| wr_busy | output | 1 | Internal write cycle in progress |
| wr_commit | output | 1 | Pulse: write the buffered bytes into the array |

## Verification
Writes are probed at the edge addresses 0x00, 0x7F, 0x80 and 0xFF under each combination of pin level and lock state. This separates the half-array lock boundary from the whole-array pin protection. Lock commands are issued with the pin high, with the lock already set, with and without the high-voltage qualifier, and together with the test load. Each outcome is visible through `cmd_ok`, `lock_code_ack` and the address map that follows. Complete write cycles are timed for an allowed and for a blocked target, which shows that protection changes only the commit pulse and not the busy length. A second start is injected mid-cycle to show that it is ignored.

// File: rtl/wp_pkg.sv
package wp_pkg;
  // Address lies in the software-lockable lower half.
  function automatic logic f_lower_half(input logic [7:0] addr, input int aw);
    logic [7:0] lim;
    lim = 8'(1 << (aw - 1));
    return (addr < lim);
  endfunction

  // Combined write permission from pin, lock and address.
  function automatic logic f_write_ok(input logic pin, input logic locked,
                                      input logic lower);
    if (pin) return 1'b0;
    if (locked && lower) return 1'b0;
    return 1'b1;
  endfunction
endpackage

// File: rtl/wp_lock_reg.sv
module wp_lock_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic prot_pin,
  input  logic set_req,
  input  logic clr_req,
  input  logic hv_ok,
  input  logic tl_en,
  input  logic tl_val,
  output logic locked,
  output logic cmd_done,
  output logic cmd_ok
);
  logic clr_hit;
  logic set_hit;

  assign clr_hit = clr_req && hv_ok;
  assign set_hit = set_req && !prot_pin && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked   <= 1'b0;
      cmd_done <= 1'b0;
      cmd_ok   <= 1'b0;
    end else begin
      cmd_done <= set_req || clr_req;
      cmd_ok   <= clr_req ? hv_ok : set_hit;
      if (tl_en)        locked <= tl_val;
      else if (clr_hit) locked <= 1'b0;
      else if (set_hit) locked <= 1'b1;
    end
  end

  // R6: a set lock survives everything except a qualified clear or test load
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(clr_req && hv_ok) && !tl_en) |=> locked);
  // R4: pin high refuses setting
  p_set_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && set_req && prot_pin && !tl_en) |=> !locked);
  // R7: qualified clear releases the lock
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && hv_ok && !tl_en) |=> !locked);
endmodule

// File: rtl/wp_gate.sv
module wp_gate #(
  parameter int ADDR_W = 8
) (
  input  logic              prot_pin,
  input  logic              locked,
  input  logic [ADDR_W-1:0] addr,
  output logic              lower_hit,
  output logic              wr_allow,
  output logic              lock_code_ack
);
  import wp_pkg::*;

  always_comb begin
    lower_hit     = f_lower_half(8'(addr), ADDR_W);
    wr_allow      = f_write_ok(prot_pin, locked, lower_hit);
    lock_code_ack = !locked;
  end
endmodule

// File: rtl/wp_wcycle.sv
module wp_wcycle #(
  parameter int WC_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic allow,
  output logic busy,
  output logic commit
);
  localparam int CW = (WC_CYCLES > 2) ? $clog2(WC_CYCLES) : 1;

  logic [CW-1:0] cnt;
  logic          keep;
  logic          last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      keep   <= 1'b0;
      commit <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= CW'(WC_CYCLES - 1);
          keep <= allow;
        end
      end else if (last) begin
        busy   <= 1'b0;
        commit <= keep;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R8: commit only at the end of a busy period
  p_commit_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (!busy && $past(busy)));
  // R9: a running cycle is not cut short or restarted
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/wp_ctrl.sv
module wp_ctrl #(
  parameter int ADDR_W    = 8,
  parameter int WC_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_pin,
  input  logic              lock_set_req,
  input  logic              lock_clr_req,
  input  logic              hv_ok,
  input  logic              tl_en,
  input  logic              tl_val,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_start,
  output logic              wr_allow,
  output logic              lock_code_ack,
  output logic              cmd_done,
  output logic              cmd_ok,
  output logic              wr_busy,
  output logic              wr_commit
);
  logic locked;
  logic lower_hit;

  wp_lock_reg u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .prot_pin (prot_pin),
    .set_req  (lock_set_req),
    .clr_req  (lock_clr_req),
    .hv_ok    (hv_ok),
    .tl_en    (tl_en),
    .tl_val   (tl_val),
    .locked   (locked),
    .cmd_done (cmd_done),
    .cmd_ok   (cmd_ok)
  );

  wp_gate #(.ADDR_W(ADDR_W)) u_gate (
    .prot_pin      (prot_pin),
    .locked        (locked),
    .addr          (wr_addr),
    .lower_hit     (lower_hit),
    .wr_allow      (wr_allow),
    .lock_code_ack (lock_code_ack)
  );

  wp_wcycle #(.WC_CYCLES(WC_CYCLES)) u_wc (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (wr_start),
    .allow  (wr_allow),
    .busy   (wr_busy),
    .commit (wr_commit)
  );

  // R3: pin high never lets a write through the gate
  p_pin_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prot_pin |-> !wr_allow);
  // R2: a locked lower-half address is refused
  p_lower_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_code_ack && lower_hit) |-> !wr_allow);
endmodule

// File: tb/tb_wp_ctrl.sv
module tb_wp_ctrl;
  localparam int WC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prot_pin = 1'b0, lock_set_req = 1'b0, lock_clr_req = 1'b0;
  logic       hv_ok = 1'b0, tl_en = 1'b0, tl_val = 1'b0, wr_start = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic       wr_allow, lock_code_ack, cmd_done, cmd_ok, wr_busy, wr_commit;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  wp_ctrl #(.ADDR_W(8), .WC_CYCLES(WC)) dut (
    .clk(clk), .rst_n(rst_n), .prot_pin(prot_pin),
    .lock_set_req(lock_set_req), .lock_clr_req(lock_clr_req), .hv_ok(hv_ok),
    .tl_en(tl_en), .tl_val(tl_val), .wr_addr(wr_addr), .wr_start(wr_start),
    .wr_allow(wr_allow), .lock_code_ack(lock_code_ack), .cmd_done(cmd_done),
    .cmd_ok(cmd_ok), .wr_busy(wr_busy), .wr_commit(wr_commit));

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // Expected permission, restated from the requirement text.
  function automatic int exp_allow(input bit pin, input bit lk, input int a);
    if (pin == 1'b1) return 0;
    if (lk && a <= 127) return 0;
    return 1;
  endfunction

  task automatic probe_map(input string req, input bit lk);
    int addrs[4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
    foreach (addrs[i]) begin
      wr_addr = 8'(addrs[i]);
      #1;
      chk_eq(req, int'(wr_allow), exp_allow(prot_pin, lk, addrs[i]));
    end
  endtask

  task automatic lock_cmd(input bit set, input bit clr, input bit hv,
                          input int exp_ok, input string req);
    @(negedge clk);
    lock_set_req = set; lock_clr_req = clr; hv_ok = hv;
    @(negedge clk);
    lock_set_req = 0; lock_clr_req = 0; hv_ok = 0;
    chk_eq(req, int'(cmd_done), 1);
    chk_eq(req, int'(cmd_ok), exp_ok);
  endtask

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_eq("R1 ack", int'(lock_code_ack), 1);
    chk_eq("R1 busy", int'(wr_busy), 0);
    chk_eq("R1 commit", int'(wr_commit), 0);
    chk_eq("R1 done", int'(cmd_done), 0);
  endtask

  task automatic t_open_map;
    prot_pin = 0;
    probe_map("R2 unlocked", 1'b0);
  endtask

  task automatic t_pin_block;
    prot_pin = 1;
    probe_map("R3 pin unlocked", 1'b0);
    prot_pin = 0;
  endtask

  task automatic t_set_refused;
    prot_pin = 1;
    lock_cmd(1, 0, 0, 0, "R4 refused");
    prot_pin = 0;
    chk_eq("R4 ack still", int'(lock_code_ack), 1);
    probe_map("R4 map", 1'b0);
  endtask

  task automatic t_set_ok;
    lock_cmd(1, 0, 0, 1, "R5 accepted");
    chk_eq("R5 ack dropped", int'(lock_code_ack), 0);
    probe_map("R2 locked", 1'b1);
    prot_pin = 1;
    probe_map("R3 pin locked", 1'b1);
    prot_pin = 0;
  endtask

  task automatic t_locked_cmds;
    lock_cmd(1, 0, 0, 0, "R6 reset");
    lock_cmd(0, 1, 0, 0, "R6 clr no hv");
    chk_eq("R6 ack", int'(lock_code_ack), 0);
    probe_map("R6 map", 1'b1);
  endtask

  task automatic t_clear;
    lock_cmd(1, 1, 1, 1, "R7 clear priority");
    chk_eq("R7 ack back", int'(lock_code_ack), 1);
    probe_map("R7 map", 1'b0);
  endtask

  task automatic t_write(input bit lk, input logic [7:0] a, input bit inject);
    int nb = 0;
    int exp_c;
    exp_c = exp_allow(prot_pin, lk, int'(a));
    @(negedge clk);
    wr_addr = a; wr_start = 1;
    @(negedge clk);
    wr_start = 0;
    while (wr_busy && nb < 4 * WC) begin
      nb++;
      chk_eq("R8 no early commit", int'(wr_commit), 0);
      if (inject && nb == 3) begin
        wr_addr = 8'hFF; wr_start = 1;
      end else begin
        wr_start = 0;
      end
      @(negedge clk);
    end
    wr_start = 0;
    chk_eq(inject ? "R9 busy len" : "R8 busy len", nb, WC);
    chk_eq(inject ? "R9 commit" : "R8 commit", int'(wr_commit), exp_c);
    @(negedge clk);
    chk_eq("R8 single pulse", int'(wr_commit), 0);
    chk_eq("R9 no restart", int'(wr_busy), 0);
  endtask

  task automatic t_test_load;
    @(negedge clk);
    tl_en = 1; tl_val = 1; lock_clr_req = 1; hv_ok = 1;
    @(negedge clk);
    tl_en = 0; lock_clr_req = 0; hv_ok = 0;
    chk_eq("R10 load set", int'(lock_code_ack), 0);
    @(negedge clk);
    tl_en = 1; tl_val = 0;
    @(negedge clk);
    tl_en = 0;
    chk_eq("R10 load clear", int'(lock_code_ack), 1);
  endtask

  initial begin
    t_reset();
    t_open_map();
    t_pin_block();
    t_set_refused();
    t_set_ok();
    t_locked_cmds();
    t_write(1'b1, 8'h10, 1'b0);   // blocked by lock
    t_write(1'b1, 8'hA0, 1'b0);   // allowed upper half
    t_write(1'b1, 8'h20, 1'b1);   // blocked, second start mid-cycle
    prot_pin = 1;
    t_write(1'b1, 8'hC0, 1'b0);   // blocked by pin
    prot_pin = 0;
    t_clear();
    t_write(1'b0, 8'h05, 1'b0);   // allowed after clear
    t_test_load();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule